// File: doc/BRIEF.md
# Two-Cycle SDRAM Address/Command Launcher

This block sits between a memory controller and the address/command pins of a DDR or DDR2 SDRAM. It runs on the double-rate command clock and uses two-cycle command timing. Each command occupies a slot of two clock cycles. Address, bank and the three command strobes are held for the whole slot. Chip select, clock enable and on-die termination take the command's values only in the slot's second cycle, which is the one cycle in which the DRAM samples the command.

The controller offers one command at a time on a valid/ready handshake. A command is made of a command kind, a bank, an address, and clock-enable and termination values. Ready rises once per slot, in its second cycle, so the next command can be taken at the slot boundary. Commands offered back to back therefore reach the DRAM as one command every two cycles, with chip select pulsing low on alternate cycles. When no command is offered at a boundary, the launcher fills the slot with an idle NOP.

Top module: `ddr_cmd_launcher`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it is released, the outputs show NOP (ras_n/cas_n/we_n = 111) with cs_n high, cke low, odt low, address and bank zero, and `cmd_ready` low.
- R2: `cmd_ready` is low in the first cycle after reset and then alternates, high in every second cycle. A high cycle marks the second cycle of the slot on the pins.
- R3: A command is taken at the rising edge where both `cmd_valid` and `cmd_ready` are high. Its address and bank appear on `mem_addr`/`mem_ba` from the next cycle and stay unchanged for exactly two cycles.
- R4: `cmd_kind` drives ras_n/cas_n/we_n as follows: 0 NOP=111, 1 PRECHARGE=010, 2 ACTIVATE=011, 3 WRITE=100, 4 READ=101. The reserved codes 5 to 7 drive 111.
- R5: `mem_cs_n` is high in the first cycle of every slot. In the second cycle it is low only if the slot carries a taken command.
- R6: `mem_cke` takes the command's clock-enable value in the second cycle of a command slot and keeps its previous value in every other cycle.
- R7: `mem_odt` equals the command's termination value in the second cycle of a command slot and is low in every other cycle.
- R8: A slot that starts with no command taken is an idle slot: it drives NOP with address and bank zero and keeps cs_n high in both cycles.
- R9: Commands that are offered continuously are launched one per two cycles, so that a run of five commands gives exactly five cs_n low cycles in ten cycles, at alternate cycles.
- R10: `cmd_valid` and the command fields have no effect while `cmd_ready` is low. Only the values present at the edge where ready is high reach the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate address/command clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Controller offers a command |
| cmd_ready | output | 1 | Launcher takes a command at this edge |
| cmd_kind | input | 3 | Command kind code (see R4) |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_addr | input | ADDR_W | Row/column address of the command |
| cmd_cke | input | 1 | Clock-enable value for the command |
| cmd_odt | input | 1 | Termination value for the command |
| mem_addr | output | ADDR_W | DRAM address pins |
| mem_ba | output | BANK_W | DRAM bank pins |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_cke | output | 1 | Clock enable |
| mem_odt | output | 1 | On-die termination |

## Verification
If the slot phase is wrong, it shows within one cycle: ready and the chip-select strobe fall out of their alternating pattern, and address or command strobes change in the middle of a slot. If a wrong command is latched, the address, bank or strobe code on the pins is wrong for the two cycles that follow the accepting edge. If the clock-enable or termination state is wrong, it shows in the strobe cycle of the next slot, or right away if cke changes or odt rises outside a strobe cycle. A per-cycle reference model compares every output at each falling edge, so any such fault is caught within two cycles.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;
  typedef enum logic [2:0] {
    K_NOP = 3'd0,
    K_PRE = 3'd1,
    K_ACT = 3'd2,
    K_WR  = 3'd3,
    K_RD  = 3'd4
  } cmd_kind_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  // R4: kind code to row/column/write strobe levels; reserved codes idle
  function automatic strobe_t kind_to_strobe(input logic [2:0] kind);
    strobe_t s;
    case (kind)
      K_PRE:   s = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      K_ACT:   s = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
      K_WR:    s = '{ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
      K_RD:    s = '{ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
      default: s = STROBE_IDLE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cmdl_phase.sv
module cmdl_phase (
  input  logic clk,
  input  logic rst,
  output logic second
);
  // second=1 marks the second cycle of the slot on the pins
  always_ff @(posedge clk) begin
    if (rst) second <= 1'b0;
    else     second <= ~second;
  end
endmodule

// File: rtl/cmdl_slot.sv
module cmdl_slot
  import cmdl_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              take,
  input  logic [2:0]        kind,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cke_in,
  input  logic              odt_in,
  output logic [ADDR_W-1:0] q_addr,
  output logic [BANK_W-1:0] q_bank,
  output strobe_t           q_strobe,
  output logic              q_live,
  output logic              q_cke,
  output logic              q_odt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_addr   <= '0;
      q_bank   <= '0;
      q_strobe <= STROBE_IDLE;
      q_live   <= 1'b0;
      q_cke    <= 1'b0;
      q_odt    <= 1'b0;
    end else if (boundary) begin
      if (take) begin
        q_addr   <= addr;
        q_bank   <= bank;
        q_strobe <= kind_to_strobe(kind);
        q_live   <= 1'b1;
        q_cke    <= cke_in;
        q_odt    <= odt_in;
      end else begin
        q_addr   <= '0;
        q_bank   <= '0;
        q_strobe <= STROBE_IDLE;
        q_live   <= 1'b0;
        q_odt    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmdl_strobe.sv
module cmdl_strobe (
  input  logic clk,
  input  logic rst,
  input  logic second,
  input  logic live,
  input  logic slot_cke,
  input  logic slot_odt,
  output logic cs_n,
  output logic cke,
  output logic odt
);
  // edge entering the second cycle: strobe; edge leaving it: deselect
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n <= 1'b1;
      cke  <= 1'b0;
      odt  <= 1'b0;
    end else if (!second) begin
      cs_n <= ~live;
      if (live) cke <= slot_cke;
      odt  <= live & slot_odt;
    end else begin
      cs_n <= 1'b1;
      odt  <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_cmd_launcher.sv
module ddr_cmd_launcher
  import cmdl_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_kind,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_cke,
  input  logic              cmd_odt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BANK_W-1:0] mem_ba,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_cs_n,
  output logic              mem_cke,
  output logic              mem_odt
);
  logic    slot_phase;
  logic    take;
  logic    slot_live;
  logic    slot_cke;
  logic    slot_odt;
  strobe_t slot_strobe;

  cmdl_phase i_phase (.clk(clk), .rst(rst), .second(slot_phase));

  assign cmd_ready = slot_phase;
  assign take      = cmd_valid & cmd_ready;

  cmdl_slot #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_slot (
    .clk(clk), .rst(rst), .boundary(slot_phase), .take(take),
    .kind(cmd_kind), .bank(cmd_bank), .addr(cmd_addr),
    .cke_in(cmd_cke), .odt_in(cmd_odt),
    .q_addr(mem_addr), .q_bank(mem_ba), .q_strobe(slot_strobe),
    .q_live(slot_live), .q_cke(slot_cke), .q_odt(slot_odt)
  );

  assign mem_ras_n = slot_strobe.ras_n;
  assign mem_cas_n = slot_strobe.cas_n;
  assign mem_we_n  = slot_strobe.we_n;

  cmdl_strobe i_strobe (
    .clk(clk), .rst(rst), .second(slot_phase), .live(slot_live),
    .slot_cke(slot_cke), .slot_odt(slot_odt),
    .cs_n(mem_cs_n), .cke(mem_cke), .odt(mem_odt)
  );
endmodule

// File: rtl/cmdl_checker.sv
module cmdl_checker #(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              take,
  input logic [ADDR_W-1:0] addr,
  input logic [BANK_W-1:0] ba,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              cs_n,
  input logic              cke,
  input logic              odt
);
  // R2
  ready_alternates_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  // R2
  ready_returns_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ready);
  // R3
  addr_held_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> $stable({addr, ba, ras_n, cas_n, we_n}));
  // R5
  first_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> cs_n);
  // R5
  taken_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> ##1 !cs_n);
  // R6
  cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> $stable(cke));
  // R7
  odt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !odt);
  // R8
  idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !take) |=> (cs_n && addr == '0 && {ras_n, cas_n, we_n} == 3'b111));
endmodule

bind ddr_cmd_launcher cmdl_checker #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_chk (
  .clk(clk), .rst(rst), .ready(cmd_ready), .take(take),
  .addr(mem_addr), .ba(mem_ba), .ras_n(mem_ras_n), .cas_n(mem_cas_n),
  .we_n(mem_we_n), .cs_n(mem_cs_n), .cke(mem_cke), .odt(mem_odt)
);

// File: tb/test_ddr_cmd_launcher.sv
`timescale 1ns/1ps
module test_ddr_cmd_launcher;
  localparam int AW = 14;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_kind = '0;
  logic [BW-1:0] cmd_bank = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_cke = 1'b0, cmd_odt = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_ba;
  logic mem_ras_n, mem_cas_n, mem_we_n, mem_cs_n, mem_cke, mem_odt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ddr_cmd_launcher #(.ADDR_W(AW), .BANK_W(BW)) i_ddr_cmd_launcher (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_cke(cmd_cke), .cmd_odt(cmd_odt), .mem_addr(mem_addr), .mem_ba(mem_ba),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_cs_n(mem_cs_n), .mem_cke(mem_cke), .mem_odt(mem_odt)
  );

  // R4 restated from the code table
  function automatic logic [2:0] want_rcw(input logic [2:0] k);
    logic [2:0] t;
    t = 3'b111;
    if (k == 3'd1) t = 3'b010;
    if (k == 3'd2) t = 3'b011;
    if (k == 3'd3) t = 3'b100;
    if (k == 3'd4) t = 3'b101;
    return t;
  endfunction

  // reference state, advanced per rising edge from the requirements
  logic m_second, m_live, m_kcke, m_kodt, m_cs_n, m_cke, m_odt, m_took;
  logic [AW-1:0] m_addr;
  logic [BW-1:0] m_ba;
  logic [2:0] m_rcw;

  always @(posedge clk) begin
    m_took <= 1'b0;
    if (rst) begin
      m_second <= 0; m_live <= 0; m_kcke <= 0; m_kodt <= 0;
      m_cs_n <= 1; m_cke <= 0; m_odt <= 0;
      m_addr <= '0; m_ba <= '0; m_rcw <= 3'b111;
    end else begin
      m_second <= !m_second;
      if (m_second) begin
        m_cs_n <= 1; m_odt <= 0;
        if (cmd_valid) begin
          m_took <= 1'b1;
          m_live <= 1; m_addr <= cmd_addr; m_ba <= cmd_bank;
          m_rcw <= want_rcw(cmd_kind); m_kcke <= cmd_cke; m_kodt <= cmd_odt;
        end else begin
          m_live <= 0; m_addr <= '0; m_ba <= '0; m_rcw <= 3'b111;
        end
      end else begin
        m_cs_n <= !m_live;
        if (m_live) m_cke <= m_kcke;
        m_odt <= m_live && m_kodt;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2 ready", 32'(cmd_ready), 32'(m_second));
      check("R3 addr", 32'(mem_addr), 32'(m_addr));
      check("R3 bank", 32'(mem_ba), 32'(m_ba));
      check("R4 strobes", 32'({mem_ras_n, mem_cas_n, mem_we_n}), 32'(m_rcw));
      check("R5 cs_n", 32'(mem_cs_n), 32'(m_cs_n));
      check("R6 cke", 32'(mem_cke), 32'(m_cke));
      check("R7 odt", 32'(mem_odt), 32'(m_odt));
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // offer a command and hold it until taken
  task automatic send(input logic [2:0] k, input logic [BW-1:0] b,
                      input logic [AW-1:0] a, input logic ck, input logic od);
    cmd_valid = 1; cmd_kind = k; cmd_bank = b; cmd_addr = a;
    cmd_cke = ck; cmd_odt = od;
    do @(negedge clk); while (!m_took);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  int lows;

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1 cs_n", 32'(mem_cs_n), 32'd1);
    check("R1 cke", 32'(mem_cke), 32'd0);
    check("R1 strobes", 32'({mem_ras_n, mem_cas_n, mem_we_n}), 32'h7);
    check("R1 ready", 32'(cmd_ready), 32'd0);
    rst = 0;
    @(negedge clk);
    // R1: first cycle after release
    check("R1 addr", 32'(mem_addr), 32'd0);
    check("R1 odt", 32'(mem_odt), 32'd0);
    // R8: idle slots
    repeat (4) @(negedge clk);
    check("R8 idle cs_n", 32'(mem_cs_n), 32'd1);
    // NOP, PRECHARGE, ACTIVATE then a write run
    send(3'd0, 3'd0, '0, 1'b1, 1'b0);
    send(3'd1, 3'd2, 14'h0400, 1'b1, 1'b0);
    send(3'd2, 3'd2, 14'h0123, 1'b1, 1'b0);
    // R9: five writes back to back, count strobes over ten cycles
    lows = 0;
    for (int i = 0; i < 5; i++) begin
      cmd_valid = 1; cmd_kind = 3'd3; cmd_bank = 3'd2;
      cmd_addr = AW'(i * 4); cmd_cke = 1; cmd_odt = 1;
      do begin
        @(negedge clk);
        if (i > 0 && !mem_cs_n) lows++;
      end while (!m_took);
    end
    cmd_valid = 0;
    repeat (2) begin @(negedge clk); if (!mem_cs_n) lows++; end
    check("R9 strobe count", 32'(lows), 32'd5);
    // R10: fields offered while ready is low are not used
    while (m_second) @(negedge clk);
    cmd_valid = 1; cmd_kind = 3'd4; cmd_addr = 14'h3AAA; cmd_bank = 3'd7;
    @(negedge clk);
    cmd_kind = 3'd4; cmd_addr = 14'h0055; cmd_bank = 3'd1;
    @(negedge clk);
    cmd_valid = 0;
    check("R10 addr", 32'(mem_addr), 32'h0055);
    check("R4 read", 32'({mem_ras_n, mem_cas_n, mem_we_n}), 32'h5);
    // R6: cke drops only in a strobe cycle
    send(3'd0, 3'd0, '0, 1'b0, 1'b0);
    cmd_valid = 0;
    @(negedge clk);
    check("R6 cke low", 32'(mem_cke), 32'd0);
    // constrained random traffic, including reserved kinds
    for (int n = 0; n < 3000; n++) begin
      cmd_valid = ($urandom % 10) < 7;
      cmd_kind = 3'($urandom % 8);
      cmd_bank = BW'($urandom);
      cmd_addr = AW'($urandom);
      cmd_cke = ($urandom % 4) != 0;
      cmd_odt = $urandom % 2;
      @(negedge clk);
    end
    cmd_valid = 0;
    repeat (4) @(negedge clk);
    summary();
  end
endmodule